// File: doc/BRIEF.md
# SPI Flash Two-Byte Streaming Programmer

This block copies a region of a local byte buffer into serial flash using the flash's two-byte streaming program mode, in which the array address advances on its own after every pair of data bytes. A start pulse supplies a 24-bit flash address and a byte count. The block then reads the buffer two bytes at a time through a read port with one cycle of latency, starting at buffer index 0. It builds every command as a chip-select window of bytes and passes those bytes one at a time to an external byte shifter.

Pairs that already hold the erased value are never sent. A group of consecutive pairs that are not erased forms a run. The first word of a run carries the address. Each later word carries only its data. Between words the block polls the flash status until the flash is no longer busy. The block closes every run with a write-disable command. If the status read after a word does not match what streaming mode requires, the block closes the run, raises a sticky error and stops.

Top module: `spi_aai_programmer`

## Requirements
- R1: The number of words is the byte count divided by two, rounded up. When the count is odd, the high byte of the last word is taken as 0xFF and is not read from the buffer.
- R2: A word whose two bytes are both 0xFF produces no shifter traffic. The flash address still advances by 2, modulo 2^24.
- R3: A run starts with status poll windows {0x05, 0xA5}, repeated until bit 0 of the returned status is 0. Next comes the window {0x06}, then the window {0xAD, A[23:16], A[15:8], A[7:0], lo, hi}. Here lo is the buffer byte at the even index and hi is the byte that follows it.
- R4: Every later word of the same run is sent as the window {0xAD, lo, hi}, with no address.
- R5: After each 0xAD window the block sends poll windows {0x05, 0xA5} until status bit 0 reads 0. The accepted status has bits 6 and 1 set and bits 5 to 2 clear. Bit 7 is ignored.
- R6: A run ends when the next word is erased or no words remain. The block then sends the window {0x04} before it skips or finishes.
- R7: Once no non-erased word remains, no further 0xAD window is sent. A byte count of 0, or a buffer that is entirely erased, ends the transfer with no shifter traffic at all.
- R8: A rejected status sends {0x04}, sets err and ends the transfer. err stays set until the next accepted start clears it.
- R9: done is a one-cycle pulse that marks the end of every transfer. busy rises on the cycle after an accepted start, is low while done is high, and any start that arrives while busy is high is ignored.
- R10: Each command occupies its own chip-select window. A shifter start is issued only while spi_sel is high. spi_sel stays low for at least one cycle between windows and is low whenever busy is low.
- R11: The buffer read port is enabled only while busy is high, and read data is taken one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; sampled only while idle |
| flash_addr | input | 24 | First flash byte address |
| byte_cnt | input | CNT_W | Number of buffer bytes to program |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Sticky status-mismatch flag |
| rd_en | output | 1 | Buffer read enable |
| rd_addr | output | CNT_W | Buffer byte index |
| rd_data | input | 8 | Buffer byte, one cycle after rd_addr |
| spi_sel | output | 1 | Chip select, active high |
| sh_start | output | 1 | Shifter byte request pulse |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shifter finished a byte |
| sh_rx | input | 8 | Byte shifted in during that transfer |

## Verification
The assertions assume that the shifter raises sh_done exactly once for each sh_start, and only after at least one cycle. They also assume that start is a single-cycle pulse. The bench shifter model answers every request after a fixed delay. It drives start for one cycle only, and it issues one extra start during a transfer to check that it is ignored. The flash model returns busy for a fixed number of polls after every streamed word, and it can force protect bits into the status once a chosen word has been programmed.

// File: rtl/spi_aai_pkg.sv
package spi_aai_pkg;
  localparam int FADDR_W   = 24;
  localparam int FRAME_MAX = 6;
  localparam int FLEN_W    = $clog2(FRAME_MAX + 1);

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_STREAM = 8'hAD;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] PAD_TX    = 8'hA5;
  localparam logic [7:0] BLANK     = 8'hFF;

  // status bits that must match after a streamed word: bit 6 and bit 1 set, 5..2 clear
  localparam logic [7:0] ST_MASK   = 8'h7E;
  localparam logic [7:0] ST_GOOD   = 8'h42;

  typedef logic [FRAME_MAX-1:0][7:0] frame_t;

  typedef enum logic [1:0] {W_IDLE, W_SEND, W_WAIT} win_state_t;

  typedef enum logic [3:0] {
    Q_IDLE, Q_CHECK, Q_FETCH, Q_EVAL, Q_PRE_POLL, Q_WREN,
    Q_PROG, Q_POST_POLL, Q_WRDI, Q_NEXT, Q_FINISH
  } seq_state_t;
endpackage

// File: rtl/spi_aai_fetch.sv
module spi_aai_fetch
  import spi_aai_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pf_req,
  input  logic [CNT_W-1:0] pf_idx,
  input  logic             pf_hi_present,
  output logic             rd_en,
  output logic [CNT_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             pf_valid,
  output logic [7:0]       pf_lo,
  output logic [7:0]       pf_hi
);
  // phase 0 idle, 1 second address out, 2 low byte back, 3 high byte back
  logic [1:0]       ph;
  logic [CNT_W-1:0] nxt_q;
  logic             hip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 2'd0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      nxt_q    <= '0;
      hip_q    <= 1'b0;
      pf_valid <= 1'b0;
      pf_lo    <= 8'h00;
      pf_hi    <= 8'h00;
    end else begin
      pf_valid <= 1'b0;
      case (ph)
        2'd0: begin
          if (pf_req) begin
            rd_en   <= 1'b1;
            rd_addr <= pf_idx;
            nxt_q   <= pf_idx + 1'b1;
            hip_q   <= pf_hi_present;
            ph      <= 2'd1;
          end
        end
        2'd1: begin
          rd_addr <= nxt_q;
          rd_en   <= hip_q;
          ph      <= 2'd2;
        end
        2'd2: begin
          rd_en <= 1'b0;
          pf_lo <= rd_data;
          ph    <= 2'd3;
        end
        default: begin
          pf_hi    <= hip_q ? rd_data : BLANK;
          pf_valid <= 1'b1;
          ph       <= 2'd0;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_aai_window.sv
module spi_aai_window
  import spi_aai_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              win_start,
  input  logic [FLEN_W-1:0] win_len,
  input  frame_t            win_bytes,
  output logic              win_done,
  output logic [7:0]        win_rx,
  output logic              spi_sel,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);
  win_state_t        wst;
  frame_t            bytes_q;
  logic [FLEN_W-1:0] len_q;
  logic [FLEN_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst      <= W_IDLE;
      bytes_q  <= '0;
      len_q    <= '0;
      pos_q    <= '0;
      win_done <= 1'b0;
      win_rx   <= 8'h00;
      spi_sel  <= 1'b0;
      sh_start <= 1'b0;
      sh_tx    <= 8'h00;
    end else begin
      win_done <= 1'b0;
      sh_start <= 1'b0;
      case (wst)
        W_IDLE: begin
          if (win_start) begin
            bytes_q <= win_bytes;
            len_q   <= win_len;
            pos_q   <= '0;
            spi_sel <= 1'b1;
            wst     <= W_SEND;
          end
        end
        W_SEND: begin
          sh_start <= 1'b1;
          sh_tx    <= bytes_q[pos_q];
          wst      <= W_WAIT;
        end
        W_WAIT: begin
          if (sh_done) begin
            win_rx <= sh_rx;
            if (pos_q == len_q - 1'b1) begin
              spi_sel  <= 1'b0;
              win_done <= 1'b1;
              wst      <= W_IDLE;
            end else begin
              pos_q <= pos_q + 1'b1;
              wst   <= W_SEND;
            end
          end
        end
        default: wst <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_aai_seq.sv
module spi_aai_seq
  import spi_aai_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FADDR_W-1:0] flash_addr,
  input  logic [CNT_W-1:0]   byte_cnt,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               pf_req,
  output logic [CNT_W-1:0]   pf_idx,
  output logic               pf_hi_present,
  input  logic               pf_valid,
  input  logic [7:0]         pf_lo,
  input  logic [7:0]         pf_hi,
  output logic               win_start,
  output logic [FLEN_W-1:0]  win_len,
  output frame_t             win_bytes,
  input  logic               win_done,
  input  logic [7:0]         win_rx
);
  localparam int WC_W = CNT_W + 1;

  seq_state_t         qst;
  seq_state_t         after_wrdi;
  logic [FADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   idx_q;
  logic [WC_W-1:0]    left_q;
  logic               in_run;
  logic               launched;

  logic [WC_W-1:0]    words_w;
  logic               pair_blank;
  logic               status_ok;
  logic [WC_W-1:0]    hi_pos;

  assign words_w    = ({1'b0, byte_cnt} + 1'b1) >> 1;
  assign pair_blank = (pf_lo == BLANK) && (pf_hi == BLANK);
  assign status_ok  = (win_rx & ST_MASK) == ST_GOOD;
  assign hi_pos     = {1'b0, idx_q} + 1'b1;

  // launch a command window; its contents depend on the state that owns it
  task automatic launch(input logic [FLEN_W-1:0] n, input frame_t b);
    win_start <= 1'b1;
    win_len   <= n;
    win_bytes <= b;
    launched  <= 1'b1;
  endtask

  always_ff @(posedge clk) begin
    if (rst) begin
      qst           <= Q_IDLE;
      after_wrdi    <= Q_FINISH;
      addr_q        <= '0;
      cnt_q         <= '0;
      idx_q         <= '0;
      left_q        <= '0;
      in_run        <= 1'b0;
      launched      <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
      pf_req        <= 1'b0;
      pf_idx        <= '0;
      pf_hi_present <= 1'b0;
      win_start     <= 1'b0;
      win_len       <= '0;
      win_bytes     <= '0;
    end else begin
      done      <= 1'b0;
      pf_req    <= 1'b0;
      win_start <= 1'b0;
      case (qst)
        Q_IDLE: begin
          if (start) begin
            addr_q <= flash_addr;
            cnt_q  <= byte_cnt;
            left_q <= words_w;
            idx_q  <= '0;
            in_run <= 1'b0;
            err    <= 1'b0;
            busy   <= 1'b1;
            qst    <= Q_CHECK;
          end
        end
        Q_CHECK: begin
          if (left_q == '0) begin
            if (in_run) begin
              in_run     <= 1'b0;
              after_wrdi <= Q_FINISH;
              qst        <= Q_WRDI;
            end else begin
              qst <= Q_FINISH;
            end
          end else begin
            pf_req        <= 1'b1;
            pf_idx        <= idx_q;
            pf_hi_present <= hi_pos < {1'b0, cnt_q};
            qst           <= Q_FETCH;
          end
        end
        Q_FETCH: begin
          if (pf_valid) qst <= Q_EVAL;
        end
        Q_EVAL: begin
          if (pair_blank) begin
            if (in_run) begin
              in_run     <= 1'b0;
              after_wrdi <= Q_NEXT;
              qst        <= Q_WRDI;
            end else begin
              qst <= Q_NEXT;
            end
          end else if (in_run) begin
            qst <= Q_PROG;
          end else begin
            qst <= Q_PRE_POLL;
          end
        end
        Q_PRE_POLL: begin
          if (!launched) begin
            launch(FLEN_W'(2), {32'h0, PAD_TX, OP_STATUS});
          end else if (win_done) begin
            launched <= 1'b0;
            if (!win_rx[0]) qst <= Q_WREN;
          end
        end
        Q_WREN: begin
          if (!launched) begin
            launch(FLEN_W'(1), {40'h0, OP_WREN});
          end else if (win_done) begin
            launched <= 1'b0;
            qst      <= Q_PROG;
          end
        end
        Q_PROG: begin
          if (!launched) begin
            if (in_run)
              launch(FLEN_W'(3), {24'h0, pf_hi, pf_lo, OP_STREAM});
            else
              launch(FLEN_W'(6), {pf_hi, pf_lo, addr_q[7:0], addr_q[15:8],
                                  addr_q[23:16], OP_STREAM});
          end else if (win_done) begin
            launched <= 1'b0;
            in_run   <= 1'b1;
            qst      <= Q_POST_POLL;
          end
        end
        Q_POST_POLL: begin
          if (!launched) begin
            launch(FLEN_W'(2), {32'h0, PAD_TX, OP_STATUS});
          end else if (win_done) begin
            launched <= 1'b0;
            if (!win_rx[0]) begin
              if (status_ok) begin
                qst <= Q_NEXT;
              end else begin
                err        <= 1'b1;
                in_run     <= 1'b0;
                after_wrdi <= Q_FINISH;
                qst        <= Q_WRDI;
              end
            end
          end
        end
        Q_WRDI: begin
          if (!launched) begin
            launch(FLEN_W'(1), {40'h0, OP_WRDI});
          end else if (win_done) begin
            launched <= 1'b0;
            qst      <= after_wrdi;
          end
        end
        Q_NEXT: begin
          addr_q <= addr_q + 2'd2;
          idx_q  <= idx_q + 2'd2;
          left_q <= left_q - 1'b1;
          qst    <= Q_CHECK;
        end
        Q_FINISH: begin
          busy <= 1'b0;
          done <= 1'b1;
          qst  <= Q_IDLE;
        end
        default: qst <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_aai_programmer.sv
module spi_aai_programmer
  import spi_aai_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [23:0]         flash_addr,
  input  logic [CNT_W-1:0]    byte_cnt,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                rd_en,
  output logic [CNT_W-1:0]    rd_addr,
  input  logic [7:0]          rd_data,
  output logic                spi_sel,
  output logic                sh_start,
  output logic [7:0]          sh_tx,
  input  logic                sh_done,
  input  logic [7:0]          sh_rx
);
  logic              pf_req;
  logic [CNT_W-1:0]  pf_idx;
  logic              pf_hi_present;
  logic              pf_valid;
  logic [7:0]        pf_lo;
  logic [7:0]        pf_hi;
  logic              win_start;
  logic [FLEN_W-1:0] win_len;
  frame_t            win_bytes;
  logic              win_done;
  logic [7:0]        win_rx;

  spi_aai_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .flash_addr(flash_addr),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .err(err),
    .pf_req(pf_req), .pf_idx(pf_idx), .pf_hi_present(pf_hi_present),
    .pf_valid(pf_valid), .pf_lo(pf_lo), .pf_hi(pf_hi),
    .win_start(win_start), .win_len(win_len), .win_bytes(win_bytes),
    .win_done(win_done), .win_rx(win_rx)
  );

  spi_aai_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .pf_req(pf_req), .pf_idx(pf_idx),
    .pf_hi_present(pf_hi_present), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pf_valid(pf_valid), .pf_lo(pf_lo), .pf_hi(pf_hi)
  );

  spi_aai_window u_win (
    .clk(clk), .rst(rst), .win_start(win_start), .win_len(win_len),
    .win_bytes(win_bytes), .win_done(win_done), .win_rx(win_rx),
    .spi_sel(spi_sel), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );
endmodule

// File: rtl/spi_aai_checker.sv
module spi_aai_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic spi_sel,
  input logic sh_start,
  input logic rd_en
);
  p_shift_in_window_r10: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> spi_sel);

  p_idle_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sel);

  p_select_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_sel) |=> !spi_sel);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !(start && !busy)) |=> err);

  p_read_when_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

bind spi_aai_programmer spi_aai_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .spi_sel(spi_sel), .sh_start(sh_start), .rd_en(rd_en)
);

// File: tb/test_spi_aai_programmer.sv
module test_spi_aai_programmer;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;
  localparam int BUSY_N = 2;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] flash_addr = '0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic busy, done, err, rd_en, spi_sel, sh_start;
  logic [CNT_W-1:0] rd_addr;
  logic [7:0] sh_tx;
  logic [7:0] rd_data = 8'h00;
  logic sh_done = 1'b0;
  logic [7:0] sh_rx = 8'h00;

  int errors = 0;
  int checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_aai_programmer #(.CNT_W(CNT_W)) i_spi_aai_programmer (
    .clk(clk), .rst(rst), .start(start), .flash_addr(flash_addr),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .err(err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .spi_sel(spi_sel), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );

  logic [7:0] mem [0:63];
  logic [5:0] seen_addr = '0;

  // expected window stream
  logic [7:0] exp_q[$];
  int exp_len[$];
  bit exp_err;

  // flash model state
  logic [7:0] cur[$];
  bit f_wel, f_aai;
  int busy_cnt = 0;
  int prog_cnt = 0;
  int fail_idx = -1;
  int sh_cnt = 0;
  bit prev_sel = 1'b0;
  int done_cnt = 0;

  task automatic fail_msg(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
  endtask

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) fail_msg(req, what, act, expv);
  endtask

  function automatic logic [7:0] respond();
    logic [7:0] s;
    if (cur.size() == 2 && cur[0] == 8'h05) begin
      s = {1'b0, f_aai, 3'b000, (fail_idx >= 0 && prog_cnt > fail_idx), f_wel, busy_cnt != 0};
      if (busy_cnt != 0) busy_cnt--;
      return s;
    end
    return 8'h00;
  endfunction

  task automatic window_end();
    int n;
    bit bad;
    string tag;
    logic [7:0] eop;
    checks++;
    if (exp_len.size() == 0) begin
      fail_msg("R7", "unexpected window opcode", cur[0], 0);
    end else begin
      n = exp_len.pop_front();
      eop = exp_q[0];
      if (eop == 8'h05) tag = "R5";
      else if (eop == 8'h04) tag = "R6";
      else if (eop == 8'hAD && n == 3) tag = "R4";
      else tag = "R3";
      bad = (cur.size() != n);
      for (int i = 0; i < n; i++) begin
        logic [7:0] eb;
        eb = exp_q.pop_front();
        if (i >= cur.size() || cur[i] != eb) bad = 1'b1;
      end
      if (bad) fail_msg(tag, "window (len<<8|first byte)",
                        (cur.size() << 8) | cur[0], (n << 8) | eop);
    end
    if (cur[0] == 8'h06) f_wel = 1'b1;
    if (cur[0] == 8'hAD) begin f_aai = 1'b1; busy_cnt = BUSY_N; prog_cnt++; end
    if (cur[0] == 8'h04) begin f_wel = 1'b0; f_aai = 1'b0; end
    cur.delete();
  endtask

  // buffer, shifter and flash model, all driven away from the active edge
  always @(negedge clk) begin
    rd_data = mem[seen_addr];
    seen_addr = rd_addr[5:0];
    sh_done = 1'b0;
    if (sh_cnt != 0) begin
      sh_cnt--;
      if (sh_cnt == 0) begin sh_done = 1'b1; sh_rx = respond(); end
    end
    if (!rst && sh_start) begin cur.push_back(sh_tx); sh_cnt = LAT; end
    if (prev_sel && !spi_sel) window_end();
    prev_sel = spi_sel;
    if (!rst) begin
      check("R10", "shifter start outside select", sh_start && !spi_sel, 0);
      check("R10", "select while idle", !busy && spi_sel, 0);
      check("R11", "read enable while idle", rd_en && !busy, 0);
      if (done) begin
        done_cnt++;
        check("R9", "busy during done", busy, 0);
      end
    end
  end

  task automatic push_w(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
    logic [7:0] b [6];
    b = '{b0, b1, b2, b3, b4, b5};
    exp_len.push_back(n);
    for (int i = 0; i < n; i++) exp_q.push_back(b[i]);
  endtask

  task automatic build(input int addr, input int cnt, input int fail);
    int words, a, p;
    bit run;
    logic [7:0] lo, hi;
    words = (cnt + 1) / 2; a = addr; p = 0; run = 0; exp_err = 0;
    for (int w = 0; w < words; w++) begin
      lo = mem[2*w];
      hi = (2*w + 1 < cnt) ? mem[2*w+1] : 8'hFF;
      if (lo == 8'hFF && hi == 8'hFF) begin
        if (run) begin push_w(1, 8'h04, 0, 0, 0, 0, 0); run = 0; end
        a = (a + 2) & 24'hFFFFFF;
        continue;
      end
      if (!run) begin
        push_w(2, 8'h05, 8'hA5, 0, 0, 0, 0);
        push_w(1, 8'h06, 0, 0, 0, 0, 0);
        push_w(6, 8'hAD, 8'(a >> 16), 8'(a >> 8), 8'(a), lo, hi);
        run = 1;
      end else begin
        push_w(3, 8'hAD, lo, hi, 0, 0, 0);
      end
      for (int k = 0; k <= BUSY_N; k++) push_w(2, 8'h05, 8'hA5, 0, 0, 0, 0);
      if (p == fail) begin
        push_w(1, 8'h04, 0, 0, 0, 0, 0);
        exp_err = 1; run = 0;
        break;
      end
      p++;
      a = (a + 2) & 24'hFFFFFF;
    end
    if (run) push_w(1, 8'h04, 0, 0, 0, 0, 0);
  endtask

  task automatic fill_seq();
    for (int i = 0; i < 64; i++) mem[i] = 8'(i + 1);
  endtask

  task automatic run_case(input string tag, input int addr, input int cnt,
                          input int fail, input bit poke);
    int t;
    build(addr, cnt, fail);
    fail_idx = fail; prog_cnt = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; flash_addr = 24'(addr); byte_cnt = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    check(tag, "busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; flash_addr = 24'h000000; byte_cnt = CNT_W'(2);
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(tag, "done pulses seen (R9)", done_cnt, 1);
    check(tag, "windows left unsent (R7)", exp_len.size(), 0);
    check("R8", "err flag", err, exp_err);
    check("R9", "busy after done", busy, 0);
    exp_len.delete(); exp_q.delete();
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL R9: watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill_seq();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "reset busy", busy, 0);
    check("R9", "reset done", done, 0);
    check("R8", "reset err", err, 0);
    check("R10", "reset select", spi_sel, 0);
    check("R11", "reset read enable", rd_en, 0);

    // R3 R4 R5 R6: one run of four words
    fill_seq();
    run_case("R4", 24'h012340, 8, -1, 0);

    // R2: erased pair splits runs, address wraps past 2^24
    fill_seq(); mem[2] = 8'hFF; mem[3] = 8'hFF;
    run_case("R2", 24'hFFFFFC, 10, -1, 0);

    // R1: odd count, pad byte goes out as 0xFF
    fill_seq();
    run_case("R1", 24'h000100, 7, -1, 0);

    // R1: odd count whose lone last byte is 0xFF makes an erased word
    fill_seq(); mem[8] = 8'hFF;
    run_case("R1", 24'h000200, 9, -1, 0);

    // R7: leading and trailing erased pairs
    fill_seq();
    for (int i = 0; i < 4; i++) mem[i] = 8'hFF;
    for (int i = 6; i < 12; i++) mem[i] = 8'hFF;
    run_case("R7", 24'h004000, 12, -1, 0);

    // R2 R7: fully erased buffer
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    run_case("R2", 24'h000000, 6, -1, 0);

    // R7: zero count
    fill_seq();
    run_case("R7", 24'h000010, 0, -1, 0);

    // R8: status rejected after the second word
    fill_seq();
    run_case("R8", 24'h030000, 8, 1, 0);

    // R8 R9: clean run clears err; start while busy is ignored
    fill_seq();
    run_case("R9", 24'h050006, 12, -1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule